// File: doc/BRIEF.md
# Paged Monochrome Display Controller

This block drives a 128 by 64 one-bit display from a 32-bit register bus. Software first writes a mode word to the control register. One exact value selects data mode and one selects command mode. Any other value leaves the controller in an invalid mode, in which writes to the data register are dropped.

Page-select codes choose one of eight horizontal bands, each eight rows tall, and reset the column to 0. Software can issue them through the instruction register at any time, or through the data register while in command mode. In data mode each byte written to the data register lands at the current page and column, and the column then advances. A byte fills one column of its page: bit 0 is the top row of the band and bit 7 the bottom row.

A separate scanout port takes an x,y coordinate and returns that pixel one clock later, so panel timing logic can fetch pixels as it needs them. The display RAM is not cleared by reset.

Top module: `mono_lcd_ctrl`

## Requirements
- R1: A control write (offset 0x1AC) of exactly 0x00100011 selects data mode, and exactly 0x00104011 selects command mode. Any other value selects invalid mode, in which data-register writes change neither the RAM nor the page or column.
- R2: An instruction-register write (offset 0x1BC) of a value from 0xB0 to 0xB7 sets the page to value minus 0xB0 and the column to 0, in any mode. Any other value changes nothing.
- R3: In command mode, a data-register write (offset 0x1C0) follows the page-select rule of R2 and never stores into the RAM.
- R4: In data mode, a data-register write stores bits 7:0 at byte page*128 + column, then advances the column by one. Column 127 wraps to 0 and the page is unchanged.
- R5: Pixel (x,y), with x from 0 to 127 and y from 0 to 63, is bit (y mod 8) of byte x + (y div 8)*128.
- R6: Offset 0x180 is a 32-bit read/write storage register. Every other offset reads as 0. Read data appears on rdata_o one clock after addr_i is presented.
- R7: Reset selects invalid mode, page 0 and column 0, and clears the 0x180 register. Display RAM contents survive reset.
- R8: px_o shows the pixel addressed by px_x_i and px_y_i as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register byte offset for writes and reads |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Registered read data for addr_i |
| px_x_i | input | 7 | Scanout column |
| px_y_i | input | 6 | Scanout row |
| px_o | output | 1 | Scanout pixel, one cycle after coordinate |

## Verification
Register writes take effect at the edge that samples them. A pixel written by a data-register write can therefore be read back by a coordinate presented in the following cycle, and that pixel appears on px_o one edge later. Register reads follow the same one-edge delay from addr_i to rdata_o. The bench changes all inputs on the falling edge and samples results on the next falling edge, which puts every comparison exactly one rising edge after its stimulus. Checks of ignored writes look at pixels that the write would have altered, or at where a following byte lands.

// File: rtl/mono_lcd_pkg.sv
package mono_lcd_pkg;
  localparam int DATA_W = 32;

  localparam logic [11:0] OFF_IRQ_CTRL = 12'h180;
  localparam logic [11:0] OFF_MODE     = 12'h1AC;
  localparam logic [11:0] OFF_INSTR    = 12'h1BC;
  localparam logic [11:0] OFF_DATA     = 12'h1C0;

  localparam logic [DATA_W-1:0] MAGIC_DATA   = 32'h0010_0011;
  localparam logic [DATA_W-1:0] MAGIC_CMD    = 32'h0010_4011;
  localparam logic [DATA_W-1:0] PAGE_CMD_BASE = 32'h0000_00B0;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_DATA = 2'd1,
    MODE_CMD  = 2'd2
  } mode_e;
endpackage

// File: rtl/mono_lcd_cmd.sv
module mono_lcd_cmd
  import mono_lcd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int COLS   = 128,
  parameter int PAGES  = 8,
  localparam int COL_W  = $clog2(COLS),
  localparam int PAGE_W = $clog2(PAGES),
  localparam int RAM_AW = $clog2(COLS * PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              mem_we_o,
  output logic [RAM_AW-1:0] mem_waddr_o,
  output logic [7:0]        mem_wdata_o
);
  mode_e             mode_q;
  logic [PAGE_W-1:0] page_q;
  logic [COL_W-1:0]  col_q;

  logic              wr_mode, wr_instr, wr_data;
  logic [DATA_W-1:0] pg_off;
  logic              is_page_cmd, page_sel;

  always_comb begin
    wr_mode     = wr_en_i && (addr_i == ADDR_W'(OFF_MODE));
    wr_instr    = wr_en_i && (addr_i == ADDR_W'(OFF_INSTR));
    wr_data     = wr_en_i && (addr_i == ADDR_W'(OFF_DATA));
    pg_off      = wdata_i - PAGE_CMD_BASE;
    is_page_cmd = pg_off < DATA_W'(PAGES);
    page_sel    = is_page_cmd && (wr_instr || (wr_data && mode_q == MODE_CMD));
    mem_we_o    = wr_data && (mode_q == MODE_DATA);
    mem_waddr_o = RAM_AW'(page_q) * RAM_AW'(COLS) + RAM_AW'(col_q);
    mem_wdata_o = wdata_i[7:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      page_q <= '0;
      col_q  <= '0;
    end else begin
      if (wr_mode) begin
        if (wdata_i == MAGIC_DATA)     mode_q <= MODE_DATA;
        else if (wdata_i == MAGIC_CMD) mode_q <= MODE_CMD;
        else                           mode_q <= MODE_OFF;
      end
      if (page_sel) begin
        page_q <= PAGE_W'(pg_off);
        col_q  <= '0;
      end else if (mem_we_o) begin
        col_q  <= col_q + COL_W'(1);
      end
    end
  end

  AST_INVALID_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && mode_q == MODE_OFF) |=> ($stable(page_q) && $stable(col_q))); // R1

  AST_PAGE_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_instr && wdata_i >= PAGE_CMD_BASE && wdata_i < PAGE_CMD_BASE + DATA_W'(PAGES))
    |=> (col_q == '0 && page_q == $past(wdata_i[PAGE_W-1:0]))); // R2

  AST_CMD_NO_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && mode_q == MODE_CMD) |=> ($stable(col_q) || col_q == '0)); // R3

  AST_COL_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && mode_q == MODE_DATA) |=> (col_q == $past(col_q) + COL_W'(1) && $stable(page_q))); // R4
endmodule

// File: rtl/mono_lcd_vram.sv
module mono_lcd_vram #(
  parameter int COLS  = 128,
  parameter int PAGES = 8,
  localparam int COL_W  = $clog2(COLS),
  localparam int ROWS   = PAGES * 8,
  localparam int Y_W    = $clog2(ROWS),
  localparam int DEPTH  = COLS * PAGES,
  localparam int RAM_AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [RAM_AW-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [COL_W-1:0]  x_i,
  input  logic [Y_W-1:0]    y_i,
  output logic              px_o
);
  logic [7:0]        mem [DEPTH];
  logic [RAM_AW-1:0] rd_idx;
  logic [2:0]        rd_bit;

  // byte = x + band*COLS, bit = row within band
  always_comb begin
    rd_idx = RAM_AW'(y_i[Y_W-1:3]) * RAM_AW'(COLS) + RAM_AW'(x_i);
    rd_bit = y_i[2:0];
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    px_o <= mem[rd_idx][rd_bit];
  end
endmodule

// File: rtl/mono_lcd_regs.sv
module mono_lcd_regs
  import mono_lcd_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] irq_ctrl_q;
  logic              hit_irq;

  assign hit_irq = (addr_i == ADDR_W'(OFF_IRQ_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_ctrl_q <= '0;
      rdata_o    <= '0;
    end else begin
      if (wr_en_i && hit_irq) irq_ctrl_q <= wdata_i;
      rdata_o <= hit_irq ? irq_ctrl_q : '0;
    end
  end

  AST_OTHER_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != ADDR_W'(OFF_IRQ_CTRL)) |=> (rdata_o == '0)); // R6
endmodule

// File: rtl/mono_lcd_ctrl.sv
module mono_lcd_ctrl
  import mono_lcd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int COLS   = 128,
  parameter int PAGES  = 8,
  localparam int COL_W  = $clog2(COLS),
  localparam int Y_W    = $clog2(PAGES * 8),
  localparam int RAM_AW = $clog2(COLS * PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [COL_W-1:0]  px_x_i,
  input  logic [Y_W-1:0]    px_y_i,
  output logic              px_o
);
  logic              mem_we;
  logic [RAM_AW-1:0] mem_waddr;
  logic [7:0]        mem_wdata;

  mono_lcd_cmd #(.ADDR_W(ADDR_W), .COLS(COLS), .PAGES(PAGES)) u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .mem_we_o    (mem_we),
    .mem_waddr_o (mem_waddr),
    .mem_wdata_o (mem_wdata)
  );

  mono_lcd_vram #(.COLS(COLS), .PAGES(PAGES)) u_vram (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .x_i     (px_x_i),
    .y_i     (px_y_i),
    .px_o    (px_o)
  );

  mono_lcd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );
endmodule

// File: tb/mono_lcd_ctrl_tb.sv
module mono_lcd_ctrl_tb;
  localparam logic [11:0] A_IRQ  = 12'h180;
  localparam logic [11:0] A_MODE = 12'h1AC;
  localparam logic [11:0] A_INST = 12'h1BC;
  localparam logic [11:0] A_DATA = 12'h1C0;
  localparam logic [31:0] W_DATA = 32'h0010_0011;
  localparam logic [31:0] W_CMD  = 32'h0010_4011;

  typedef struct packed {
    logic        chk;   // 0: register write, 1: pixel check
    logic [3:0]  req;
    logic [11:0] addr;
    logic [31:0] data;
    logic [6:0]  x;
    logic [5:0]  y;
    logic        exp;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd2, A_INST, 32'hB0, 7'd0, 6'd0, 1'b0},        // R2 page 0
    '{1'b0, 4'd4, A_DATA, 32'hA5, 7'd0, 6'd0, 1'b0},        // R4 p0 c0
    '{1'b0, 4'd4, A_DATA, 32'h3C, 7'd0, 6'd0, 1'b0},        // R4 p0 c1
    '{1'b0, 4'd2, A_INST, 32'hB3, 7'd0, 6'd0, 1'b0},        // R2 page 3
    '{1'b0, 4'd4, A_DATA, 32'h81, 7'd0, 6'd0, 1'b0},        // p3 c0
    '{1'b0, 4'd1, A_MODE, W_CMD,  7'd0, 6'd0, 1'b0},        // R1 cmd mode
    '{1'b0, 4'd3, A_DATA, 32'hB7, 7'd0, 6'd0, 1'b0},        // R3 page 7, no store
    '{1'b0, 4'd1, A_MODE, W_DATA, 7'd0, 6'd0, 1'b0},
    '{1'b0, 4'd4, A_DATA, 32'hFF, 7'd0, 6'd0, 1'b0},        // p7 c0
    '{1'b0, 4'd2, A_INST, 32'hC0, 7'd0, 6'd0, 1'b0},        // R2 ignored
    '{1'b0, 4'd4, A_DATA, 32'h01, 7'd0, 6'd0, 1'b0},        // p7 c1
    '{1'b1, 4'd5, 12'h0,  32'h0,  7'd0, 6'd0,  1'b1},       // R5
    '{1'b1, 4'd5, 12'h0,  32'h0,  7'd0, 6'd1,  1'b0},
    '{1'b1, 4'd5, 12'h0,  32'h0,  7'd0, 6'd7,  1'b1},
    '{1'b1, 4'd4, 12'h0,  32'h0,  7'd1, 6'd1,  1'b0},       // R4
    '{1'b1, 4'd4, 12'h0,  32'h0,  7'd1, 6'd2,  1'b1},
    '{1'b1, 4'd4, 12'h0,  32'h0,  7'd1, 6'd6,  1'b0},
    '{1'b1, 4'd2, 12'h0,  32'h0,  7'd0, 6'd24, 1'b1},       // R2
    '{1'b1, 4'd2, 12'h0,  32'h0,  7'd0, 6'd25, 1'b0},
    '{1'b1, 4'd5, 12'h0,  32'h0,  7'd0, 6'd31, 1'b1},
    '{1'b1, 4'd3, 12'h0,  32'h0,  7'd1, 6'd24, 1'b0},       // R3 cmd byte not stored
    '{1'b1, 4'd3, 12'h0,  32'h0,  7'd0, 6'd63, 1'b1},       // R3 page via data reg
    '{1'b1, 4'd2, 12'h0,  32'h0,  7'd1, 6'd56, 1'b1},       // R2 bad code ignored
    '{1'b1, 4'd5, 12'h0,  32'h0,  7'd1, 6'd57, 1'b0},
    '{1'b1, 4'd8, 12'h0,  32'h0,  7'd0, 6'd56, 1'b1}        // R8
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [6:0]  px_x = '0;
  logic [5:0]  px_y = '0;
  logic        px;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mono_lcd_ctrl u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .px_x_i  (px_x),
    .px_y_i  (px_y),
    .px_o    (px)
  );

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_px(input int req, input logic [6:0] x, input logic [5:0] y, input logic e);
    px_x = x; px_y = y;
    @(negedge clk);
    checks++;
    if (px !== e) begin
      failures++;
      $display("FAIL R%0d pixel(%0d,%0d) actual=%b expected=%b", req, x, y, px, e);
    end
  endtask

  task automatic chk_rd(input int req, input logic [11:0] a, input logic [31:0] e);
    addr = a;
    @(negedge clk);
    checks++;
    if (rdata !== e) begin
      failures++;
      $display("FAIL R%0d read 0x%0h actual=0x%0h expected=0x%0h", req, a, rdata, e);
    end
  endtask

  task automatic pulse_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_rd(7, A_IRQ, 32'h0);                      // R7 reset value

    // zero the RAM: page by page, 128 bytes each
    wr(A_MODE, W_DATA);
    for (int p = 0; p < 8; p++) begin
      wr(A_INST, 32'hB0 + 32'(p));
      for (int c = 0; c < 128; c++) wr(A_DATA, 32'h0);
    end

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].chk) chk_px(int'(VEC[i].req), VEC[i].x, VEC[i].y, VEC[i].exp);
      else            wr(VEC[i].addr, VEC[i].data);
    end

    // R4 column wrap within page 5
    wr(A_INST, 32'hB5);
    for (int c = 0; c < 128; c++) wr(A_DATA, (c == 127) ? 32'h80 : 32'h00);
    wr(A_DATA, 32'h04);                            // wraps to column 0
    chk_px(4, 7'd0, 6'd42, 1'b1);
    chk_px(4, 7'd127, 6'd47, 1'b1);
    chk_px(4, 7'd127, 6'd40, 1'b0);

    // R1 invalid mode word: data write dropped, column unchanged
    wr(A_MODE, 32'h0010_0010);
    wr(A_DATA, 32'hFF);
    wr(A_MODE, W_DATA);
    wr(A_DATA, 32'h10);                            // lands at p5 c1
    chk_px(1, 7'd1, 6'd44, 1'b1);
    chk_px(1, 7'd1, 6'd40, 1'b0);

    // R6 storage register and zero reads
    wr(A_IRQ, 32'hDEAD_BEEF);
    chk_rd(6, A_IRQ, 32'hDEAD_BEEF);
    chk_rd(6, A_MODE, 32'h0);
    chk_rd(6, A_DATA, 32'h0);
    chk_rd(6, 12'h184, 32'h0);

    // R7 reset: register cleared, invalid mode, page 0 col 0, RAM kept
    pulse_reset();
    chk_rd(7, A_IRQ, 32'h0);
    chk_px(7, 7'd1, 6'd2, 1'b1);                   // 0x3C at p0 c1 survives
    wr(A_DATA, 32'hFF);                            // invalid mode: dropped
    wr(A_MODE, W_DATA);
    wr(A_DATA, 32'h08);                            // p0 c0
    chk_px(7, 7'd0, 6'd3, 1'b1);
    chk_px(7, 7'd0, 6'd0, 1'b0);
    chk_px(7, 7'd1, 6'd0, 1'b0);

    // R8 back-to-back coordinates each resolve after one edge
    chk_px(8, 7'd0, 6'd42, 1'b1);
    chk_px(8, 7'd0, 6'd43, 1'b0);
    chk_px(8, 7'd127, 6'd47, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R0 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule